// File: doc/BRIEF.md
# TLB Register Access Unit

This block is the software-visible register file that sits between a processor's special-register bus and a small translation lookaside buffer. Software uses it to select a TLB entry, write or read that entry's tag word and its 64-bit data word, and hold the current process identifier and zone-protection word. The TLB entry storage lives inside this block. Address matching is done by a separate translation datapath, which this block drives through a search request/response interface.

When the tag word is written, the current process identifier is stored with the entry. When the tag word is read, the entry's stored identifier is loaded back into the process-identifier register. A write to the search register sends the written address, with its page offset cleared, to the translator. The reply either loads the index register with the matching entry number or sets a sticky miss flag. Two configuration inputs gate all of this. One says whether an MMU is present. The other sets how much register access software has.

Top module: `mmu_sreg_if`

## Requirements
- R1: The index register is register number 4. Its low IDX_W bits select the TLB entry. A software write updates bits 30..0 only. Bit 31 is the miss flag, and a software write never changes it. Reads return all 32 bits.
- R2: A write to register 1 (entry high) stores the 8-bit process identifier into the selected entry's identifier field, in the same cycle as the tag word is written. A permitted read of register 1 with `reg_rd` high copies that entry's identifier into the process-identifier register. The process-identifier register is 8 bits wide and reads back zero-extended.
- R3: Register numbers: 0 is entry low, 1 is entry high, 2 is the process identifier, 3 is zone protection, 4 is the index and 5 is search. For the entry registers, address bit 0 picks the array: 0 picks the data array and 1 picks the tag array. Both arrays are read and written at the selected entry.
- R4: A permitted write to register 5 raises `srch_req` one cycle later. It also presents the written value with bits PAGE_LSB-1..0 cleared on `srch_vaddr`, and the current identifier on `srch_pid`. On `srch_resp` with `srch_hit` high, the index register becomes the zero-extended `srch_hit_idx`. On a miss, bit 31 is set and bits 30..0 keep their values.
- R5: A read of the search register returns zero.
- R6: When `cfg_mmu_level` is below 2 or `cfg_tlb_access` is 0, every write is ignored and every read returns zero.
- R7: Reads of registers 0, 1, 2 and 3 require bit 0 of `cfg_tlb_access`. Otherwise they return zero, and the register-1 read does not load the process identifier. Writes to registers 2, 3 and 5 require `cfg_tlb_access` greater than 1. Registers 0, 1 and 4 are writable whenever access is enabled. Register 4 is always readable when access is enabled.
- R8: With `reg_ext` high, only register 0 responds. It then reads or writes bits 63..32 of the entry data word instead of bits 31..0. An extended access to any other register is ignored and reads zero.
- R9: After reset, every register, tag word, data word and stored identifier is zero.
- R10: Register numbers 6 and 7 ignore writes and read zero.
- R11: While a search is outstanding, `srch_req` stays high until `srch_resp`. Register writes are ignored and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mmu_level | input | 2 | MMU configuration level; below 2 means no MMU |
| cfg_tlb_access | input | 2 | Software TLB access level |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_rd | input | 1 | Read strobe; enables the register-1 read side effect |
| reg_addr | input | 3 | Register number |
| reg_ext | input | 1 | Extended (upper word) access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| srch_req | output | 1 | Search request, held until response |
| srch_vaddr | output | 32 | Search address with page offset cleared |
| srch_pid | output | 8 | Current process identifier |
| zone_prot | output | 32 | Zone-protection word |
| srch_resp | input | 1 | Search response strobe |
| srch_hit | input | 1 | Search result is a hit |
| srch_hit_idx | input | IDX_W | Matching entry number |

## Verification
On every cycle, the assertions check the following. A software write to the index register keeps bit 31. A register-1 read loads the process identifier from the entry. A missed search sets the miss flag. The search register reads zero. A disabled configuration freezes the register state. A request is held until its response. The bench covers what needs history across several accesses. It sweeps every configuration level, access level, register number and extended flag, and predicts each read from a model of the requirements. The stored identifier moves between entries and the process-identifier register in both directions. The permission gating holds for each register. Accesses made while a search is pending are dropped.

// File: rtl/mmu_sreg_pkg.sv
package mmu_sreg_pkg;

  typedef enum logic [2:0] {
    RA_LO   = 3'd0,
    RA_HI   = 3'd1,
    RA_PID  = 3'd2,
    RA_ZPR  = 3'd3,
    RA_IDX  = 3'd4,
    RA_SRCH = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic wr_lo;
    logic wr_hi;
    logic wr_pid;
    logic wr_zpr;
    logic wr_idx;
    logic wr_srch;
    logic rd_hi;
    logic rd_ok;
  } acc_cmd_t;

  localparam logic [1:0] MMU_MIN_LEVEL = 2'd2;

endpackage

// File: rtl/mmu_sreg_access.sv
module mmu_sreg_access
  import mmu_sreg_pkg::*;
(
  input  logic [1:0] cfg_level,
  input  logic [1:0] cfg_acc,
  input  logic       busy,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic       reg_ext,
  output acc_cmd_t   cmd
);

  logic unit_on;
  logic legal;
  logic priv_rd;
  logic priv_wr;
  logic wr_go;

  always_comb begin
    unit_on = (cfg_level >= MMU_MIN_LEVEL) && (cfg_acc != 2'd0) && !busy;
    legal   = unit_on && !(reg_ext && (reg_addr != RA_LO));
    priv_rd = cfg_acc[0];
    priv_wr = (cfg_acc > 2'd1);
    wr_go   = legal && reg_wr;

    cmd         = '0;
    cmd.wr_lo   = wr_go && (reg_addr == RA_LO);
    cmd.wr_hi   = wr_go && (reg_addr == RA_HI);
    cmd.wr_pid  = wr_go && priv_wr && (reg_addr == RA_PID);
    cmd.wr_zpr  = wr_go && priv_wr && (reg_addr == RA_ZPR);
    cmd.wr_idx  = wr_go && (reg_addr == RA_IDX);
    cmd.wr_srch = wr_go && priv_wr && (reg_addr == RA_SRCH);

    unique case (reg_addr)
      RA_LO, RA_HI, RA_PID, RA_ZPR: cmd.rd_ok = legal && priv_rd;
      RA_IDX:                       cmd.rd_ok = legal;
      default:                      cmd.rd_ok = 1'b0;
    endcase
    cmd.rd_hi = cmd.rd_ok && reg_rd && (reg_addr == RA_HI);
  end

endmodule

// File: rtl/mmu_sreg_tlb_store.sv
module mmu_sreg_tlb_store #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned TID_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    sel,
  input  logic                wr_data,
  input  logic                wr_upper,
  input  logic                wr_tag,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [TID_W-1:0]    pid,
  output logic [WORD_W-1:0]   tag_rd,
  output logic [2*WORD_W-1:0] data_rd,
  output logic [TID_W-1:0]    tid_rd
);

  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [WORD_W-1:0]   tag_arr  [ENTRIES];
  logic [2*WORD_W-1:0] data_arr [ENTRIES];
  logic [TID_W-1:0]    tid_arr  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic                hit_e;
    logic [WORD_W-1:0]   tag_q,  tag_d;
    logic [2*WORD_W-1:0] data_q, data_d;
    logic [TID_W-1:0]    tid_q,  tid_d;

    always_comb begin
      hit_e  = (sel == IDX_W'(e));
      tag_d  = tag_q;
      data_d = data_q;
      tid_d  = tid_q;
      if (hit_e && wr_tag) begin
        tag_d = wdata;
        tid_d = pid;
      end
      if (hit_e && wr_data) begin
        if (wr_upper) data_d[2*WORD_W-1:WORD_W] = wdata;
        else          data_d[WORD_W-1:0]        = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q  <= '0;
        data_q <= '0;
        tid_q  <= '0;
      end else if (hit_e && (wr_tag || wr_data)) begin
        tag_q  <= tag_d;
        data_q <= data_d;
        tid_q  <= tid_d;
      end
    end

    assign tag_arr[e]  = tag_q;
    assign data_arr[e] = data_q;
    assign tid_arr[e]  = tid_q;
  end

  assign tag_rd  = tag_arr[sel];
  assign data_rd = data_arr[sel];
  assign tid_rd  = tid_arr[sel];

endmodule

// File: rtl/mmu_sreg_search.sv
module mmu_sreg_search #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned PAGE_LSB = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] addr_in,
  input  logic              resp,
  output logic              busy,
  output logic [WORD_W-1:0] addr_out,
  output logic              done
);

  localparam logic [WORD_W-1:0] PAGE_MASK = ~((WORD_W'(1) << PAGE_LSB) - WORD_W'(1));

  logic              busy_q, busy_d;
  logic [WORD_W-1:0] addr_q, addr_d;

  always_comb begin
    busy_d = busy_q;
    addr_d = addr_q;
    if (start) begin
      busy_d = 1'b1;
      addr_d = addr_in & PAGE_MASK;
    end else if (busy_q && resp) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (start) addr_q <= addr_d;
    end
  end

  assign busy     = busy_q;
  assign addr_out = addr_q;
  assign done     = busy_q && resp;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !resp) |=> busy_q); // R11

endmodule

// File: rtl/mmu_sreg_if.sv
module mmu_sreg_if
  import mmu_sreg_pkg::*;
#(
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned PAGE_LSB = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mmu_level,
  input  logic [1:0]       cfg_tlb_access,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic             reg_ext,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             srch_req,
  output logic [31:0]      srch_vaddr,
  output logic [7:0]       srch_pid,
  output logic [31:0]      zone_prot,
  input  logic             srch_resp,
  input  logic             srch_hit,
  input  logic [IDX_W-1:0] srch_hit_idx
);

  localparam int unsigned WORD_W = 32;
  localparam int unsigned TID_W  = 8;
  localparam int unsigned MISS_B = WORD_W - 1;

  acc_cmd_t            cmd;
  logic                busy;
  logic                srch_done;
  logic [WORD_W-1:0]   tag_rd;
  logic [2*WORD_W-1:0] data_rd;
  logic [TID_W-1:0]    tid_rd;

  logic [WORD_W-1:0]   idx_q, idx_d;
  logic [TID_W-1:0]    pid_q, pid_d;
  logic [WORD_W-1:0]   zpr_q, zpr_d;

  mmu_sreg_access u_access (
    .cfg_level (cfg_mmu_level),
    .cfg_acc   (cfg_tlb_access),
    .busy      (busy),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_ext   (reg_ext),
    .cmd       (cmd)
  );

  mmu_sreg_tlb_store #(
    .IDX_W  (IDX_W),
    .WORD_W (WORD_W),
    .TID_W  (TID_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (idx_q[IDX_W-1:0]),
    .wr_data  (cmd.wr_lo),
    .wr_upper (reg_ext),
    .wr_tag   (cmd.wr_hi),
    .wdata    (reg_wdata),
    .pid      (pid_q),
    .tag_rd   (tag_rd),
    .data_rd  (data_rd),
    .tid_rd   (tid_rd)
  );

  mmu_sreg_search #(
    .WORD_W   (WORD_W),
    .PAGE_LSB (PAGE_LSB)
  ) u_search (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd.wr_srch),
    .addr_in  (reg_wdata),
    .resp     (srch_resp),
    .busy     (busy),
    .addr_out (srch_vaddr),
    .done     (srch_done)
  );

  always_comb begin
    idx_d = idx_q;
    pid_d = pid_q;
    zpr_d = zpr_q;
    if (cmd.wr_idx) idx_d = {idx_q[MISS_B], reg_wdata[MISS_B-1:0]};
    if (srch_done) begin
      if (srch_hit) idx_d = WORD_W'(srch_hit_idx);
      else          idx_d[MISS_B] = 1'b1;
    end
    if (cmd.wr_pid) pid_d = reg_wdata[TID_W-1:0];
    if (cmd.rd_hi)  pid_d = tid_rd;
    if (cmd.wr_zpr) zpr_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      pid_q <= '0;
      zpr_q <= '0;
    end else begin
      if (cmd.wr_idx || srch_done) idx_q <= idx_d;
      if (cmd.wr_pid || cmd.rd_hi) pid_q <= pid_d;
      if (cmd.wr_zpr)              zpr_q <= zpr_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (cmd.rd_ok) begin
      unique case (reg_addr)
        RA_LO:   reg_rdata = reg_ext ? data_rd[2*WORD_W-1:WORD_W] : data_rd[WORD_W-1:0];
        RA_HI:   reg_rdata = tag_rd;
        RA_PID:  reg_rdata = WORD_W'(pid_q);
        RA_ZPR:  reg_rdata = zpr_q;
        RA_IDX:  reg_rdata = idx_q;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign srch_req  = busy;
  assign srch_pid  = pid_q;
  assign zone_prot = zpr_q;

  AST_IDX_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.wr_idx && !srch_done) |=> (idx_q[MISS_B] == $past(idx_q[MISS_B]))); // R1

  AST_HI_RD_LOADS_PID: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.rd_hi |=> (pid_q == $past(tid_rd))); // R2

  AST_MISS_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && !srch_hit) |=> idx_q[MISS_B]); // R4

  AST_SRCH_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_SRCH) |-> (reg_rdata == '0)); // R5

  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (((cfg_mmu_level < MMU_MIN_LEVEL) || (cfg_tlb_access == 2'd0)) && !busy)
      |=> ($stable(idx_q) && $stable(pid_q) && $stable(zpr_q))); // R6

endmodule

// File: tb/mmu_sreg_if_tb.sv
module mmu_sreg_if_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mmu_level = 2'd0;
  logic [1:0]  cfg_tlb_access = 2'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic        reg_ext = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        srch_req;
  logic [31:0] srch_vaddr;
  logic [7:0]  srch_pid;
  logic [31:0] zone_prot;
  logic        srch_resp = 1'b0;
  logic        srch_hit = 1'b0;
  logic [2:0]  srch_hit_idx = 3'd0;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [31:0] tag_m [8];
  logic [63:0] dat_m [8];
  logic [7:0]  tid_m [8];
  logic [31:0] idx_m = 32'd0;
  logic [7:0]  pid_m = 8'd0;
  logic [31:0] zpr_m = 32'd0;

  mmu_sreg_if u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mmu_level(cfg_mmu_level), .cfg_tlb_access(cfg_tlb_access),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_ext(reg_ext),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .srch_req(srch_req), .srch_vaddr(srch_vaddr),
    .srch_pid(srch_pid), .zone_prot(zone_prot), .srch_resp(srch_resp), .srch_hit(srch_hit),
    .srch_hit_idx(srch_hit_idx)
  );

  always #2.5 clk = ~clk;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: act=running exp=finished");
    finish_run();
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit on_f();
    return (cfg_mmu_level >= 2'd2) && (cfg_tlb_access != 2'd0);
  endfunction

  function automatic bit legal_f(input int a, input bit e);
    return on_f() && !(e && a != 0);
  endfunction

  function automatic bit rdok_f(input int a, input bit e);
    if (!legal_f(a, e)) return 0;
    if (a <= 3) return cfg_tlb_access[0];
    return a == 4;
  endfunction

  function automatic logic [31:0] exp_rd(input int a, input bit e);
    if (!rdok_f(a, e)) return 32'd0;
    case (a)
      0: return e ? dat_m[idx_m[2:0]][63:32] : dat_m[idx_m[2:0]][31:0];
      1: return tag_m[idx_m[2:0]];
      2: return {24'd0, pid_m};
      3: return zpr_m;
      default: return idx_m;
    endcase
  endfunction

  function automatic string tag_of(input int a, input bit e);
    if (!on_f()) return "R6";
    if (e && a != 0) return "R8";
    case (a)
      0, 1: return "R3";
      2, 3: return "R7";
      4: return "R1";
      5: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic do_rd(input int a, input bit e, input string tag);
    reg_addr = 3'(a);
    reg_ext  = e;
    reg_rd   = 1'b1;
    #1;
    chk(reg_rdata, exp_rd(a, e), tag);
    if (a == 1 && rdok_f(a, e)) pid_m = tid_m[idx_m[2:0]];
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_wr(input int a, input bit e, input logic [31:0] v);
    bit go;
    bit srch;
    go   = legal_f(a, e);
    srch = go && (a == 5) && (cfg_tlb_access > 2'd1);
    reg_addr  = 3'(a);
    reg_ext   = e;
    reg_wdata = v;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (go) begin
      case (a)
        0: if (e) dat_m[idx_m[2:0]][63:32] = v; else dat_m[idx_m[2:0]][31:0] = v;
        1: begin tid_m[idx_m[2:0]] = pid_m; tag_m[idx_m[2:0]] = v; end
        2: if (cfg_tlb_access > 2'd1) pid_m = v[7:0];
        3: if (cfg_tlb_access > 2'd1) zpr_m = v;
        4: idx_m = {idx_m[31], v[30:0]};
        default: ;
      endcase
    end
    #1;
    chk({31'd0, srch_req}, {31'd0, srch}, "R4 req");
    if (srch) begin
      chk(srch_vaddr, v & 32'hFFFF_FC00, "R4 vaddr");
      chk({24'd0, srch_pid}, {24'd0, pid_m}, "R4 pid");
      srch_resp    = 1'b1;
      srch_hit     = v[20];
      srch_hit_idx = v[23:21];
      @(negedge clk);
      srch_resp = 1'b0;
      if (v[20]) idx_m = {29'd0, v[23:21]};
      else       idx_m[31] = 1'b1;
    end
  endtask

  task automatic full_reads();
    cfg_mmu_level  = 2'd2;
    cfg_tlb_access = 2'd3;
    do_rd(2, 0, "R2 pid");
    do_rd(3, 0, "R7 zpr");
    do_rd(4, 0, "R4 idx");
    do_rd(0, 0, "R3 lo");
    do_rd(0, 1, "R8 lo-ext");
    do_rd(1, 0, "R2 hi");
    do_rd(2, 0, "R2 pid-after-hi");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      tag_m[i] = '0; dat_m[i] = '0; tid_m[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: everything reads zero after reset
    cfg_mmu_level  = 2'd3;
    cfg_tlb_access = 2'd3;
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a); reg_ext = 1'b0; #1;
      chk(reg_rdata, 32'd0, "R9 reset");
      reg_ext = 1'b1; #1;
      chk(reg_rdata, 32'd0, "R9 reset ext");
      @(negedge clk);
    end

    // Sweep of configuration, access level, register number and extended flag
    for (int l = 0; l < 4; l++) begin
      for (int c = 0; c < 4; c++) begin
        for (int a = 0; a < 8; a++) begin
          for (int e = 0; e < 2; e++) begin
            logic [31:0] v;
            int k;
            k = ((l * 4 + c) * 8 + a) * 2 + e + 1;
            v = (32'h6D2B_79F5 * 32'(k)) ^ (32'(k) << 20);
            cfg_mmu_level  = 2'(l);
            cfg_tlb_access = 2'(c);
            do_wr(a, e[0], v);
            for (int ra = 0; ra < 8; ra++) begin
              for (int re = 0; re < 2; re++) begin
                do_rd(ra, re[0], tag_of(ra, re[0]));
              end
            end
            full_reads();
          end
        end
      end
    end

    // R11: accesses during an outstanding search are dropped
    cfg_mmu_level  = 2'd2;
    cfg_tlb_access = 2'd3;
    do_wr(4, 0, 32'h0000_0005);
    do_wr(2, 0, 32'h0000_003C);
    reg_addr = 3'd5; reg_ext = 1'b0; reg_wdata = 32'h1234_5678; reg_wr = 1'b1;
    @(negedge clk);
    reg_addr = 3'd2; reg_wdata = 32'h0000_00A5;
    #1;
    chk({31'd0, srch_req}, 32'd1, "R11 req raised");
    reg_addr = 3'd4; #1;
    chk(reg_rdata, 32'd0, "R11 read while busy");
    reg_addr = 3'd2;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    chk({31'd0, srch_req}, 32'd1, "R11 req held");
    srch_resp = 1'b1; srch_hit = 1'b0; srch_hit_idx = 3'd0;
    @(negedge clk);
    srch_resp = 1'b0;
    #1;
    chk({31'd0, srch_req}, 32'd0, "R11 req dropped");
    idx_m = 32'h8000_0005;
    do_rd(2, 0, "R11 pid unchanged");
    do_rd(4, 0, "R4 miss keeps low bits");

    // R1: software write cannot clear the miss flag
    do_wr(4, 0, 32'h0000_0002);
    do_rd(4, 0, "R1 flag sticky");

    finish_run();
  end

endmodule